// File: doc/BRIEF.md
# Cartridge PRG Bank Register Unit

This block sits on the expansion bus of an 8-bit CPU cartridge and selects which 32 KiB slice of PRG ROM the CPU sees by driving two high ROM address lines. It sees only a few CPU address lines, so its four registers appear in a window that repeats across the expansion area. Inside it keeps three pieces of state: a 2-bit staging value, a 2-bit current value that the CPU can read back, and a 1-bit mode flag.

The current value reaches the ROM address lines only in two steps. First a register write loads it, either from the staging value (copy mode) or by adding one (step mode). Then any CPU write into ROM space copies it into the output latch that drives the bank lines. The data of that ROM-space write plays no part. The CPU bus is sampled on a fast system clock. A write takes effect when the M2 phase falls with R/W low, using the address and data that were present while M2 was high. Read data is driven combinationally while M2 is high. The bus uses plain control pins; there is no streaming interface.

Top module: `prg_bank_unit`

## Requirements
- R1: A synchronous reset (rst high at a clk edge) clears the staging value, the current value, the mode flag and the bank output latch to zero.
- R2: The register window is selected only when romsel_n=1, cpu_a14=1, cpu_a13=0 and cpu_a8=1; cpu_a1:cpu_a0 pick the register, and every other address is a mirror. Outside the window, reads do not drive data and writes change no register.
- R3: While m2=1, cpu_rw=1 and the window is selected, d_oe=1 and d_out carries the current value, with bit 1 on D5 (d_out[1]) and bit 0 on D4 (d_out[0]). Otherwise d_oe=0.
- R4: A write to register 2 (a1=1, a0=0) stores d_in[1:0] (D5:D4) in the staging value. The read value and the bank pins do not change.
- R5: A write to register 3 (a1=1, a0=1) stores d_in[0] (D4) as the mode flag. D5 is ignored.
- R6: A write to register 0 with the mode flag at 0 copies the staging value into the current value.
- R7: A write to register 0 with the mode flag at 1 adds one to the current value modulo 4, so 3 becomes 0.
- R8: A write to register 1 (a1=0, a0=1) changes no state.
- R9: A write with romsel_n=0 copies the current value to the bank pins (prg_a16 = bit 1, prg_a15 = bit 0) whatever the write data is. The bank pins change on no other event.
- R10: A write takes effect only after m2 falls. While m2 stays high, no state changes.
- R11: A read (cpu_rw=1) of any register, including register 0 in step mode, changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than M2 |
| rst | input | 1 | Synchronous reset, active high |
| m2 | input | 1 | CPU M2 phase clock |
| cpu_rw | input | 1 | CPU R/W, 1 = read |
| romsel_n | input | 1 | ROM select strobe, active low |
| cpu_a14 | input | 1 | CPU address bit 14 |
| cpu_a13 | input | 1 | CPU address bit 13 |
| cpu_a8 | input | 1 | CPU address bit 8 |
| cpu_a1 | input | 1 | CPU address bit 1 |
| cpu_a0 | input | 1 | CPU address bit 0 |
| d_in | input | 2 | CPU data bits D5:D4 as received |
| d_out | output | 2 | Read data for D5:D4 |
| d_oe | output | 1 | Drive enable for d_out onto the bus |
| prg_a16 | output | 1 | PRG ROM address line 16 |
| prg_a15 | output | 1 | PRG ROM address line 15 |

## Verification
The hardest case to reach is the wrap of the current value from 3 to 0 in step mode, while the bank pins keep showing an older value. The bench gets there by loading a known staging value, copying it, setting the mode flag and issuing repeated register-0 writes. After each write it reads the register back and checks that the bank pins have not moved, then issues one ROM-space write and checks the pins. A second hard case is a ROM write with M2 held high for several cycles, during which the pins must stay unchanged. The bench covers it with a dedicated task that checks the pins before and after the fall of M2.

// File: rtl/prg_bank_pkg.sv
package prg_bank_pkg;
  localparam int BANK_W = 2;

  typedef logic [BANK_W-1:0] bank_t;

  typedef enum logic [1:0] {
    OFS_LOAD  = 2'd0,
    OFS_NOP   = 2'd1,
    OFS_STAGE = 2'd2,
    OFS_MODE  = 2'd3
  } reg_ofs_e;

  typedef struct packed {
    logic     win;
    logic     rom;
    logic     rw;
    reg_ofs_e ofs;
    bank_t    data;
  } bus_sample_t;
endpackage

// File: rtl/prg_addr_decode.sv
module prg_addr_decode
  import prg_bank_pkg::*;
(
  input  logic     romsel_n,
  input  logic     a14,
  input  logic     a13,
  input  logic     a8,
  input  logic     a1,
  input  logic     a0,
  output logic     win,
  output logic     rom,
  output reg_ofs_e ofs
);
  // Partial decode: only these pins are visible, so the window mirrors.
  always_comb begin
    win = romsel_n & a14 & ~a13 & a8;
    rom = ~romsel_n;
    ofs = reg_ofs_e'({a1, a0});
  end
endmodule

// File: rtl/prg_bus_sampler.sv
module prg_bus_sampler
  import prg_bank_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        m2,
  input  bus_sample_t live,
  output logic        wr_stb,
  output bus_sample_t smp
);
  logic m2_q;

  // Track the bus while M2 is high; the last value seen is used at the fall.
  always_ff @(posedge clk) begin
    if (rst) begin
      m2_q <= 1'b0;
      smp  <= '0;
    end else begin
      m2_q <= m2;
      if (m2) smp <= live;
    end
  end

  assign wr_stb = m2_q & ~m2 & ~smp.rw;

  AST_STROBE_NEEDS_LOW_M2: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> !m2) else $error("strobe while m2 high"); // R10
endmodule

// File: rtl/prg_bank_regs.sv
module prg_bank_regs
  import prg_bank_pkg::*;
#(
  parameter int W = BANK_W
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_stb,
  input  bus_sample_t smp,
  output bank_t       cur,
  output bank_t       bank
);
  bank_t stage_q, cur_q, bank_q;
  logic  mode_q;
  logic  reg_wr, rom_wr;

  assign reg_wr = wr_stb & smp.win;
  assign rom_wr = wr_stb & smp.rom;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_q <= '0;
      cur_q   <= '0;
      mode_q  <= 1'b0;
      bank_q  <= '0;
    end else begin
      if (reg_wr) begin
        unique case (smp.ofs)
          OFS_LOAD:  cur_q   <= mode_q ? cur_q + bank_t'(1) : stage_q;
          OFS_STAGE: stage_q <= smp.data;
          OFS_MODE:  mode_q  <= smp.data[0];
          default:   ;
        endcase
      end
      if (rom_wr) bank_q <= cur_q;
    end
  end

  assign cur  = cur_q;
  assign bank = bank_q;

  AST_BANK_ONLY_ON_ROM: assert property (@(posedge clk) disable iff (rst)
    !rom_wr |=> $stable(bank_q)) else $error("bank moved"); // R9
  AST_STAGE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(reg_wr && smp.ofs == OFS_STAGE) |=> $stable(stage_q)) else $error("stage moved"); // R4
  AST_STEP_WRAP: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && smp.ofs == OFS_LOAD && mode_q && cur_q == bank_t'(3)) |=> cur_q == '0)
    else $error("no wrap"); // R7
  AST_NOP_REG: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && smp.ofs == OFS_NOP) |=> ($stable(cur_q) && $stable(stage_q) && $stable(mode_q)))
    else $error("nop changed state"); // R8
endmodule

// File: rtl/prg_bank_unit.sv
module prg_bank_unit
  import prg_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             m2,
  input  logic             cpu_rw,
  input  logic             romsel_n,
  input  logic             cpu_a14,
  input  logic             cpu_a13,
  input  logic             cpu_a8,
  input  logic             cpu_a1,
  input  logic             cpu_a0,
  input  logic [BANK_W-1:0] d_in,
  output logic [BANK_W-1:0] d_out,
  output logic             d_oe,
  output logic             prg_a16,
  output logic             prg_a15
);
  logic        win, rom, wr_stb;
  reg_ofs_e    ofs;
  bus_sample_t live, smp;
  bank_t       cur, bank;

  prg_addr_decode u_dec (
    .romsel_n(romsel_n), .a14(cpu_a14), .a13(cpu_a13), .a8(cpu_a8),
    .a1(cpu_a1), .a0(cpu_a0), .win(win), .rom(rom), .ofs(ofs)
  );

  assign live = '{win: win, rom: rom, rw: cpu_rw, ofs: ofs, data: d_in};

  prg_bus_sampler u_smp (
    .clk(clk), .rst(rst), .m2(m2), .live(live), .wr_stb(wr_stb), .smp(smp)
  );

  prg_bank_regs #(.W(BANK_W)) u_regs (
    .clk(clk), .rst(rst), .wr_stb(wr_stb), .smp(smp), .cur(cur), .bank(bank)
  );

  assign d_oe    = m2 & cpu_rw & win;
  assign d_out   = cur;
  assign prg_a16 = bank[1];
  assign prg_a15 = bank[0];

  AST_NO_DRIVE_IN_ROM: assert property (@(posedge clk) disable iff (rst)
    !romsel_n |-> !d_oe) else $error("drive during rom access"); // R2
  AST_NO_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (rst)
    !cpu_rw |-> !d_oe) else $error("drive during write"); // R3
endmodule

// File: tb/prg_bank_unit_tb.sv
module prg_bank_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic m2 = 1'b0, cpu_rw = 1'b1, romsel_n = 1'b1;
  logic a14 = 1'b0, a13 = 1'b0, a8 = 1'b0, a1 = 1'b0, a0 = 1'b0;
  logic [1:0] d_in = 2'b00;
  logic [1:0] d_out;
  logic d_oe, prg_a16, prg_a15;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  prg_bank_unit u_dut (
    .clk(clk), .rst(rst), .m2(m2), .cpu_rw(cpu_rw), .romsel_n(romsel_n),
    .cpu_a14(a14), .cpu_a13(a13), .cpu_a8(a8), .cpu_a1(a1), .cpu_a0(a0),
    .d_in(d_in), .d_out(d_out), .d_oe(d_oe), .prg_a16(prg_a16), .prg_a15(prg_a15)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // One bus cycle; returns what was seen on the data pins while M2 was high.
  task automatic cycle(input logic rw, input logic rsn, input logic [2:0] hi,
                       input logic [1:0] ofs, input logic [1:0] d,
                       output logic oe_s, output logic [1:0] d_s);
    @(negedge clk);
    cpu_rw = rw; romsel_n = rsn; {a14, a13, a8} = hi; {a1, a0} = ofs; d_in = d;
    m2 = 1'b1;
    repeat (2) @(negedge clk);
    oe_s = d_oe; d_s = d_out;
    m2 = 1'b0;
    repeat (2) @(negedge clk);
    cpu_rw = 1'b1; romsel_n = 1'b1; a14 = 1'b0; d_in = 2'b00;
  endtask

  task automatic reg_wr(input logic [1:0] ofs, input logic [1:0] d);
    logic oe_s; logic [1:0] d_s;
    cycle(1'b0, 1'b1, 3'b101, ofs, d, oe_s, d_s);
  endtask

  task automatic rom_wr(input logic [1:0] d);
    logic oe_s; logic [1:0] d_s;
    cycle(1'b0, 1'b0, 3'b000, 2'b00, d, oe_s, d_s);
  endtask

  task automatic read_expect(input string req, input logic [1:0] ofs, input int exp);
    logic oe_s; logic [1:0] d_s;
    cycle(1'b1, 1'b1, 3'b101, ofs, 2'b00, oe_s, d_s);
    check(req, oe_s, 1);
    check(req, d_s, exp);
  endtask

  task automatic pins_expect(input string req, input int exp);
    check(req, {prg_a16, prg_a15}, exp);
  endtask

  task automatic t_reset;
    pins_expect("R1 pins after reset", 0);
    read_expect("R1 read after reset", 2'd0, 0);
  endtask

  task automatic t_stage_copy;
    reg_wr(2'd2, 2'b10);
    read_expect("R4 stage hidden", 2'd0, 0);
    pins_expect("R4 pins unchanged", 0);
    reg_wr(2'd0, 2'b00);
    read_expect("R6 copy", 2'd0, 2);
    pins_expect("R9 pins wait for rom write", 0);
    rom_wr(2'b01);
    pins_expect("R9 rom write transfers", 2);
  endtask

  task automatic t_nop;
    reg_wr(2'd1, 2'b11);
    read_expect("R8 nop register", 2'd0, 2);
    reg_wr(2'd0, 2'b00);
    read_expect("R8 stage kept", 2'd0, 2);
  endtask

  task automatic t_step;
    reg_wr(2'd3, 2'b01);
    reg_wr(2'd0, 2'b00);
    read_expect("R7 step 2->3", 2'd0, 3);
    reg_wr(2'd0, 2'b10);
    read_expect("R7 wrap 3->0", 2'd0, 0);
    pins_expect("R9 pins held during steps", 2);
    reg_wr(2'd0, 2'b00);
    read_expect("R7 step 0->1", 2'd0, 1);
    read_expect("R11 read reg0 in step mode", 2'd0, 1);
    read_expect("R3 mirror offset 3", 2'd3, 1);
    rom_wr(2'b00);
    pins_expect("R9 data ignored", 1);
    rom_wr(2'b11);
    pins_expect("R9 data ignored again", 1);
  endtask

  task automatic t_mode_bits;
    reg_wr(2'd3, 2'b10);
    reg_wr(2'd0, 2'b00);
    read_expect("R5 D5 ignored for mode", 2'd0, 2);
  endtask

  task automatic t_decode;
    logic oe_s; logic [1:0] d_s;
    cycle(1'b0, 1'b1, 3'b100, 2'd2, 2'b01, oe_s, d_s);
    cycle(1'b0, 1'b1, 3'b111, 2'd2, 2'b01, oe_s, d_s);
    cycle(1'b0, 1'b1, 3'b001, 2'd2, 2'b01, oe_s, d_s);
    reg_wr(2'd0, 2'b00);
    read_expect("R2 outside writes ignored", 2'd0, 2);
    cycle(1'b1, 1'b1, 3'b111, 2'd0, 2'b00, oe_s, d_s);
    check("R2 no drive with a13", oe_s, 0);
    cycle(1'b1, 1'b0, 3'b101, 2'd0, 2'b00, oe_s, d_s);
    check("R2 no drive in rom", oe_s, 0);
    cycle(1'b0, 1'b1, 3'b101, 2'd0, 2'b00, oe_s, d_s);
    check("R3 no drive on write", oe_s, 0);
  endtask

  task automatic t_m2_hold;
    // current = 2, pins = 1: hold a rom write with M2 high
    @(negedge clk);
    cpu_rw = 1'b0; romsel_n = 1'b0; d_in = 2'b00;
    m2 = 1'b1;
    repeat (6) @(negedge clk);
    pins_expect("R10 no change while m2 high", 1);
    m2 = 1'b0;
    repeat (2) @(negedge clk);
    pins_expect("R10 change after fall", 2);
    cpu_rw = 1'b1; romsel_n = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_stage_copy();
    t_nop();
    t_step();
    t_mode_bits();
    t_decode();
    t_m2_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule